// File: doc/BRIEF.md
# Frame Readout Server over a Byte Serial Link

This block answers a host's request for a picture. A stored frame of RGB565 pixels (640 by 480 by default) sits in a shared frame memory behind an arbiter. When the receive side of a serial link reports a byte from the host, the block walks the frame in row-major order. It fetches each selected pixel with a single read request and pushes the pixel out as bytes to the transmit side of the link. The value of the host byte does not matter; only its arrival counts.

Two settings, taken at the moment the trigger arrives, shape the dump. The scale setting thins the picture by skipping pixels, so that full, half or quarter resolution is sent in each direction. The format setting sends each pixel either as two RGB565 bytes or as one RGB332 byte. Only one read is ever outstanding. The next pixel is not fetched until every byte of the current one has been taken by the transmitter, so the link itself paces the walk.

Top module: `frame_uart_server`

## Requirements
- R1: While reset is low, and in the cycle after, rd_req and tx_valid are low; a reset during a dump abandons it and leaves the block idle.
- R2: In idle, one cycle of host_rx_valid starts exactly one frame dump; strobes that arrive during a dump are ignored, and after the last pixel's bytes the block issues no reads and no bytes until the next trigger.
- R3: With scale shift k (cfg_scale 0, 1, 2 give k = 0, 1, 2; value 3 acts as 2), the block reads only pixels whose column and row are multiples of 2^k, at address row*FRAME_W + column, columns ascending within a row and rows ascending.
- R4: With cfg_fmt332 = 0, each pixel is sent as two bytes, bits 15:8 first, then bits 7:0.
- R5: With cfg_fmt332 = 1, each pixel is sent as one byte {p[15:13], p[10:8], p[4:3]} (red top 3 in bits 7:5, green top 3 in bits 4:2, blue top 2 in bits 1:0).
- R6: rd_req stays high with a stable rd_addr until rd_ack; it drops in the cycle after the ack; no new read starts until all bytes of the current pixel are accepted, and rd_req and tx_valid are never high together.
- R7: tx_valid, once high, stays high with a stable tx_byte until tx_ready.
- R8: cfg_scale and cfg_fmt332 are sampled with the trigger; changes during a dump have no effect on it.
- R9: The pixel used is the rd_data that comes with rd_dvalid, which may arrive any number of cycles (at least one) after rd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rx_valid | input | 1 | One-cycle strobe: a byte arrived from the host |
| cfg_scale | input | 2 | Pixel skip shift k (3 acts as 2) |
| cfg_fmt332 | input | 1 | 1: one RGB332 byte per pixel; 0: two RGB565 bytes |
| rd_req | output | 1 | Pixel read request to the frame arbiter |
| rd_addr | output | ADDR_W | Pixel address, row*FRAME_W + column |
| rd_ack | input | 1 | Arbiter accepts the request |
| rd_dvalid | input | 1 | Read data valid |
| rd_data | input | 16 | RGB565 pixel returned |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte to send |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |

## Verification
The assertions watch the handshake discipline on every cycle: the request holds with its address until acked and drops after, the offered byte holds until taken, a read never overlaps a byte offer, and reset forces both sides quiet. Address order, pixel skipping, byte order, the RGB332 packing, the ignoring of retriggers and of settings changed mid-dump, and the return to idle appear only in whole streams. The bench shows them by comparing every read address and every sent byte against a model, with stalls on both sides and several read latencies.

// File: rtl/frame_uart_pkg.sv
// Shared types and the pixel repacking rule for the frame readout server.
package frame_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_HI,
        ST_LO
    } srv_state_t;

    // Reduce an RGB565 pixel to RGB332 by keeping the top bits of each colour.
    function automatic logic [7:0] to_rgb332(input logic [15:0] p);
        return {p[15:13], p[10:8], p[4:3]};
    endfunction

endpackage

// File: rtl/frame_scan_ctr.sv
// Walks the frame in row-major order with a stride of 2^shift in both
// directions and presents the linear address of the current pixel.
// Assumes W and H are multiples of 4 and that shift stays at most 2.
module frame_scan_ctr #(
    parameter int W      = 640,
    parameter int H      = 480,
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [1:0]        shift,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int CW  = $clog2(W);
    localparam int RW  = $clog2(H);
    localparam int CW1 = CW + 1;
    localparam int RW1 = RW + 1;

    logic [CW:0] col, col_nx;
    logic [RW:0] row, row_nx;
    logic [2:0]  step;
    logic        col_wrap;

    // Next position and end-of-row / end-of-frame detection.
    always_comb begin
        step     = 3'd1 << shift;
        col_nx   = col + CW1'(step);
        row_nx   = row + RW1'(step);
        col_wrap = col_nx >= CW1'(W);
        last     = col_wrap && (row_nx >= RW1'(H));
        addr     = ADDR_W'(row) * ADDR_W'(W) + ADDR_W'(col);
    end

    // Position register: cleared on restart, stepped on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            col <= '0;
            row <= '0;
        end else if (advance) begin
            if (col_wrap) begin
                col <= '0;
                row <= row_nx;
            end else begin
                col <= col_nx;
            end
        end
    end
endmodule

// File: rtl/pix_byte_sel.sv
// Holds the fetched pixel and selects the byte to transmit: high byte,
// low byte, or the RGB332 reduction when the compact format is chosen.
module pix_byte_sel (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] pix_in,
    input  logic        fmt332,
    input  logic        low_sel,
    output logic [7:0]  byte_out
);
    import frame_uart_pkg::*;

    logic [15:0] pix_q;

    // Capture the pixel when the arbiter returns it.
    always_ff @(posedge clk) begin
        if (!rst_n)    pix_q <= '0;
        else if (load) pix_q <= pix_in;
    end

    // Byte selection for the current transmit slot.
    always_comb begin
        if (!low_sel)    byte_out = pix_q[15:8];
        else if (fmt332) byte_out = to_rgb332(pix_q);
        else             byte_out = pix_q[7:0];
    end
endmodule

// File: rtl/frame_uart_server.sv
// Frame readout server: a host strobe starts a dump of the stored frame,
// one read outstanding at a time, bytes paced by the transmitter.
// Assumes rd_dvalid arrives at least one cycle after rd_ack.
module frame_uart_server #(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    parameter int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rx_valid,
    input  logic [1:0]        cfg_scale,
    input  logic              cfg_fmt332,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic              rd_dvalid,
    input  logic [15:0]       rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready
);
    import frame_uart_pkg::*;

    srv_state_t state;
    logic [1:0] shift_q;
    logic       fmt_q;
    logic       restart, advance, last, load;

    // Decode of the walk controls from the state.
    always_comb begin
        restart  = (state == ST_IDLE) && host_rx_valid;
        advance  = (state == ST_LO) && tx_ready && !last;
        load     = (state == ST_WAIT) && rd_dvalid;
        rd_req   = (state == ST_REQ);
        tx_valid = (state == ST_HI) || (state == ST_LO);
    end

    // Dump sequencer: request, wait for data, send byte(s), repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shift_q <= '0;
            fmt_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (host_rx_valid) begin
                    shift_q <= (cfg_scale == 2'd3) ? 2'd2 : cfg_scale;
                    fmt_q   <= cfg_fmt332;
                    state   <= ST_REQ;
                end
                ST_REQ:  if (rd_ack)    state <= ST_WAIT;
                ST_WAIT: if (rd_dvalid) state <= fmt_q ? ST_LO : ST_HI;
                ST_HI:   if (tx_ready)  state <= ST_LO;
                ST_LO:   if (tx_ready)  state <= last ? ST_IDLE : ST_REQ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    frame_scan_ctr #(
        .W(FRAME_W), .H(FRAME_H), .ADDR_W(ADDR_W)
    ) scan_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
        .shift(shift_q), .addr(rd_addr), .last(last)
    );

    pix_byte_sel sel_i (
        .clk(clk), .rst_n(rst_n), .load(load), .pix_in(rd_data),
        .fmt332(fmt_q), .low_sel(state == ST_LO), .byte_out(tx_byte)
    );
endmodule

// File: rtl/frame_uart_server_chk.sv
// Handshake checker for the frame readout server, bound to every instance.
module frame_uart_server_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_ready
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_req && !tx_valid));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R6
    rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rd_req);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && tx_valid));

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

bind frame_uart_server frame_uart_server_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready)
);

// File: tb/frame_uart_server_tb_top.sv
// Bench: a small frame, a table of dump settings, then directed cases.
module frame_uart_server_tb_top;
    localparam int W  = 16;
    localparam int H  = 8;
    localparam int AW = $clog2(W * H);

    // Table fields: [21:20] scale, [19] rgb332, [18] stall, [17:16] latency, [15:0] bytes
    localparam logic [21:0] TBL [7] = '{
        {2'd0, 1'b0, 1'b0, 2'd0, 16'd256},
        {2'd1, 1'b1, 1'b1, 2'd2, 16'd32},
        {2'd2, 1'b0, 1'b1, 2'd1, 16'd16},
        {2'd0, 1'b1, 1'b1, 2'd3, 16'd128},
        {2'd1, 1'b0, 1'b0, 2'd1, 16'd64},
        {2'd2, 1'b1, 1'b0, 2'd0, 16'd8},
        {2'd3, 1'b0, 1'b1, 2'd2, 16'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rx_valid = 1'b0;
    logic [1:0] cfg_scale = '0;
    logic cfg_fmt332 = 1'b0;
    logic rd_req, tx_valid;
    logic [AW-1:0] rd_addr;
    logic rd_ack = 1'b0, rd_dvalid = 1'b0, tx_ready = 1'b0;
    logic [15:0] rd_data = '0;
    logic [7:0] tx_byte;

    int errs = 0, checks = 0;
    int cyc = 0;
    bit stall_m = 1'b0;
    int lat_m = 0, bpp_m = 2;
    int nbyte = 0, naddr = 0, bytes_since = 0, r6_bad = 0;
    logic [7:0]    byte_log [1024];
    logic [AW-1:0] addr_log [1024];
    logic [7:0]    eb [1024];
    int            ea [1024];

    always #10 clk = ~clk;

    frame_uart_server #(.FRAME_W(W), .FRAME_H(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_rx_valid(host_rx_valid),
        .cfg_scale(cfg_scale), .cfg_fmt332(cfg_fmt332),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_dvalid(rd_dvalid), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready)
    );

    function automatic logic [15:0] pixf(input int a);
        int v;
        v = a * 40503 + 12345;
        return v[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Arbiter and transmitter model: decides inputs at each falling edge and
    // logs the handshakes that will complete at the next rising edge.
    initial begin
        bit pend = 1'b0;
        int lat_cnt = 0;
        logic [AW-1:0] pend_addr = '0;
        forever begin
            bit new_ack, new_tr;
            @(negedge clk);
            cyc++;
            rd_dvalid = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
                rd_ack = 1'b0;
                tx_ready = 1'b0;
            end else begin
                new_tr  = stall_m ? (cyc % 3 != 0) : 1'b1;
                new_ack = rd_req && !pend && (!stall_m || (cyc % 2 == 0));
                if (pend) begin
                    if (lat_cnt == 0) begin
                        rd_dvalid = 1'b1;
                        rd_data   = pixf(int'(pend_addr));
                        pend      = 1'b0;
                    end else lat_cnt--;
                end
                if (rd_req && new_ack) begin
                    if (naddr > 0 && bytes_since != bpp_m) r6_bad++;
                    if (naddr < 1024) addr_log[naddr] = rd_addr;
                    naddr++;
                    bytes_since = 0;
                    pend = 1'b1;
                    pend_addr = rd_addr;
                    lat_cnt = lat_m;
                end
                if (tx_valid && new_tr) begin
                    if (nbyte < 1024) byte_log[nbyte] = tx_byte;
                    nbyte++;
                    bytes_since++;
                end
                rd_ack = new_ack;
                tx_ready = new_tr;
            end
        end
    end

    // One complete dump, optionally with a retrigger and settings change mid-way.
    task automatic run_frame(input logic [1:0] sc, input bit f, input bit st,
                             input int lt, input int exp_cnt, input bit retrig);
        int k, s, np, nb, t, bad, first_bad;
        k = (sc == 2'd3) ? 2 : int'(sc);
        s = 1 << k;
        np = 0; nb = 0;
        for (int r = 0; r < H; r += s) begin
            for (int c = 0; c < W; c += s) begin
                logic [15:0] p;
                ea[np] = r * W + c;
                p = pixf(r * W + c);
                np++;
                if (f) begin
                    eb[nb] = {p[15:13], p[10:8], p[4:3]};
                    nb++;
                end else begin
                    eb[nb] = p[15:8];
                    eb[nb + 1] = p[7:0];
                    nb += 2;
                end
            end
        end
        stall_m = st; lat_m = lt; bpp_m = f ? 1 : 2;
        nbyte = 0; naddr = 0; bytes_since = 0; r6_bad = 0;
        @(negedge clk);
        cfg_scale = sc; cfg_fmt332 = f; host_rx_valid = 1'b1;
        @(negedge clk);
        host_rx_valid = 1'b0;
        if (retrig) begin
            t = 0;
            while (nbyte < 4 && t < 5000) begin @(negedge clk); t++; end
            cfg_scale = ~sc; cfg_fmt332 = ~f; host_rx_valid = 1'b1;
            @(negedge clk);
            host_rx_valid = 1'b0;
        end
        t = 0;
        while (nbyte < exp_cnt && t < 20000) begin @(negedge clk); t++; end
        repeat (40) @(negedge clk);
        // R2: exactly one frame of bytes, nothing after the last pixel
        check(nbyte == exp_cnt, "R2", "byte count", nbyte, exp_cnt);
        // R3: read addresses follow the skipped row-major walk
        check(naddr == np, "R3", "read count", naddr, np);
        bad = 0; first_bad = -1;
        for (int i = 0; i < np && i < naddr; i++)
            if (int'(addr_log[i]) != ea[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, "R3", "address mismatches",
              (first_bad < 0) ? 0 : int'(addr_log[first_bad]),
              (first_bad < 0) ? 0 : ea[first_bad]);
        // R4 R5 R7 R9: byte stream content under stalls and read latency
        bad = 0; first_bad = -1;
        for (int i = 0; i < nb && i < nbyte; i++)
            if (byte_log[i] != eb[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, f ? "R5" : "R4", "byte content",
              (first_bad < 0) ? 0 : int'(byte_log[first_bad]),
              (first_bad < 0) ? 0 : int'(eb[first_bad]));
        // R6: next read only after the whole pixel was taken
        check(r6_bad == 0, "R6", "early read count", r6_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rd_req && !tx_valid, "R1", "outputs in reset",
              int'({rd_req, tx_valid}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R2: no activity without a trigger
        check(nbyte == 0 && naddr == 0 && !rd_req, "R2", "idle activity",
              nbyte + naddr, 0);

        // Table of dump settings
        for (int i = 0; i < 7; i++) begin
            logic [21:0] e;
            e = TBL[i];
            run_frame(e[21:20], e[19], e[18], int'(e[17:16]), int'(e[15:0]), 1'b0);
        end

        // R8 R2: retrigger and settings change mid-dump have no effect
        run_frame(2'd1, 1'b0, 1'b1, 1, 64, 1'b1);

        // R1: reset in the middle of a dump
        stall_m = 1'b1; lat_m = 1; bpp_m = 2;
        nbyte = 0; naddr = 0; bytes_since = 0;
        @(negedge clk);
        cfg_scale = 2'd0; cfg_fmt332 = 1'b0; host_rx_valid = 1'b1;
        @(negedge clk);
        host_rx_valid = 1'b0;
        while (nbyte < 10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!rd_req && !tx_valid, "R1", "outputs after mid-dump reset",
              int'({rd_req, tx_valid}), 0);
        rst_n = 1'b1;
        held = nbyte;
        repeat (20) @(negedge clk);
        check(nbyte == held && !rd_req, "R1", "activity after reset",
              nbyte - held, 0);
        // Clean dump after the abandoned one
        run_frame(2'd2, 1'b1, 1'b1, 2, 8, 1'b0);
        finish_run();
    end
endmodule